// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This block sits between a synchronous host port and an asynchronous 16-bit DRAM that has separate upper and lower column strobes and supports fast page cycles. Each host request carries a word address, a write flag, two byte enables and write data. The controller splits the address into a row half and a column half and drives them one after the other on a shared address bus. It then produces the row strobe, the two column strobes, the write strobe and the output-enable strobe. All timing intervals are parameters counted in clock cycles.

After an access the row stays open with the row strobe held low. A later request to the same row is served as a page cycle with no new row activation. The row is closed in four cases: a request targets a different row, the refresh side asks for the bus, the page has been open too long, or the row sits unused until that same limit expires. The controller also enforces the minimum row-strobe low time and the row precharge time.

Refresh scheduling lives outside this block. It raises a request line, and the controller answers with a grant once the memory is precharged and quiet. Read data returns with a one-cycle valid strobe.

Top module: `pgdram_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, the outputs are idle: row, column, write and output-enable strobes inactive (high), the data driver disabled, and both `rd_valid` and `ref_gnt` low.
- R2: A request address is split as row = upper `AW` bits and column = lower `AW` bits. The row is on `dram_addr` when the row strobe falls. The column is on `dram_addr` when a column strobe falls and stays stable while it is low.
- R3: The first column strobe of an access falls more than `T_RCD` cycles after the row strobe falls.
- R4: A column strobe stays low for exactly `T_CAS` cycles. Between two column accesses in one open row, the column strobes stay high for at least `T_CP` cycles. A column strobe is only low while the row strobe is low.
- R5: Byte enable bit 0 selects the lower lane (data bits 7:0, `dram_cas_n[0]`). Bit 1 selects the upper lane (bits 15:8, `dram_cas_n[1]`). Only the strobes of enabled lanes go low.
- R6: For a write, the write strobe is low and the data driver is on with `dram_dq_out` equal to the write data when the column strobe falls, and the output enable stays high whenever the driver is on.
- R7: For a read, the output enable is low and the write strobe high while the column strobe is low. Data is captured on the last low cycle. `rd_valid` pulses for one cycle in the cycle after the strobe rises, and `rd_data` holds the read word with the lanes of disabled bytes forced to zero. Reads return in request order.
- R8: A request to the currently open row is served with no new falling edge of the row strobe.
- R9: A request to a different row closes the open row. The row strobe stays high for at least `T_RP` cycles before it falls again.
- R10: Each row-strobe low period lasts at least `T_RAS_MIN` and at most `T_RASP_MAX` cycles. The row is closed when the limit approaches, even if requests keep hitting it or none arrive.
- R11: While `ref_req` is high, the open row is closed. `ref_gnt` then rises with every strobe inactive and `req_ready` low, and no request is accepted until `ref_req` falls.
- R12: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the controller is idle, or when the row is open and the request hits it. It is low in the cycle after an acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take the request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*AW | Word address, row in upper half |
| req_be | input | 2 | Byte enables, bit 0 lower lane |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 16 | Read data, disabled lanes zero |
| ref_req | input | 1 | Refresh side wants the memory |
| ref_gnt | output | 1 | Memory precharged and released to refresh |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 2 | Column strobes, bit 0 lower lane |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | AW | Multiplexed row/column address |
| dram_dq_out | output | 16 | Data toward the memory |
| dram_dq_oe | output | 1 | Data driver enable |
| dram_dq_in | input | 16 | Data from the memory |

## Verification
The bench builds the controller with `AW` = 4, so a behavioural memory of 256 words sits behind the strobes, and a 16-row space gives many row hits and misses under random traffic. `T_RASP_MAX` is reduced to 40 cycles, which makes the forced page close reachable within a few back-to-back hits and closes idle rows in tens of cycles. The other timing parameters keep their defaults, so the measured strobe intervals are the ones used in the design.

// File: rtl/pgdram_pkg.sv
package pgdram_pkg;

    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int DW     = LANES * LANE_W;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROWSET,
        ST_RCD,
        ST_COLSET,
        ST_CASLO,
        ST_CASPRE,
        ST_OPEN,
        ST_PRECH,
        ST_REFGNT
    } phase_e;

    function automatic logic [DW-1:0] lane_mask(input logic [LANES-1:0] be);
        logic [DW-1:0] m;
        for (int l = 0; l < LANES; l++) begin
            m[l*LANE_W +: LANE_W] = {LANE_W{be[l]}};
        end
        return m;
    endfunction

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/pgdram_phase_timer.sv
module pgdram_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/pgdram_page_guard.sv
module pgdram_page_guard #(
    parameter int T_RAS_MIN  = 7,
    parameter int T_RASP_MAX = 12500,
    parameter int T_COLUMN   = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic ras_low,
    output logic min_ok,
    output logic expired
);

    localparam int CW    = $clog2(T_RASP_MAX + 1);
    localparam int LIMIT = T_RASP_MAX - 2 - T_COLUMN;
    localparam logic [CW-1:0] CMAX    = CW'(T_RASP_MAX);
    localparam logic [CW-1:0] LIMIT_C = CW'(LIMIT);
    localparam logic [CW-1:0] MIN_C   = CW'(T_RAS_MIN - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!ras_low) begin
            cnt_q <= '0;
        end else if (cnt_q != CMAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign min_ok  = (cnt_q >= MIN_C);
    assign expired = (cnt_q >= LIMIT_C);

    // R10: the low period never reaches past the page-mode maximum
    a_r10_ras_max: assert property (@(posedge clk) disable iff (rst)
        ras_low |-> (cnt_q < CMAX));

    // R10: a low period ends only after the minimum pulse width
    a_r10_ras_min: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_low) |-> ($past(cnt_q) >= MIN_C));

endmodule

// File: rtl/pgdram_ctrl.sv
module pgdram_ctrl
    import pgdram_pkg::*;
#(
    parameter int AW         = 10,
    parameter int T_RCD      = 3,
    parameter int T_CAS      = 3,
    parameter int T_CP       = 2,
    parameter int T_RP       = 4,
    parameter int T_RAS_MIN  = 7,
    parameter int T_RASP_MAX = 12500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [2*AW-1:0]   req_addr,
    input  logic [LANES-1:0]  req_be,
    input  logic [DW-1:0]     req_wdata,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    input  logic              ref_req,
    output logic              ref_gnt,
    output logic              dram_ras_n,
    output logic [LANES-1:0]  dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [AW-1:0]     dram_addr,
    output logic [DW-1:0]     dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DW-1:0]     dram_dq_in
);

    localparam int TW = $clog2(max_of4(T_RCD, T_CAS, T_CP, T_RP) + 1);

    typedef struct packed {
        logic             write;
        logic [AW-1:0]    row;
        logic [AW-1:0]    col;
        logic [LANES-1:0] be;
        logic [DW-1:0]    wdata;
    } access_t;

    phase_e          st_q, st_d;
    access_t         cur_q;
    logic            tmr_load;
    logic [TW-1:0]   tmr_val;
    logic            tmr_done;
    logic            ras_low;
    logic            min_ok;
    logic            expired;
    logic            row_hit;
    logic            close_want;
    logic            accept;
    logic            rd_grab;
    logic            wr_phase;

    pgdram_phase_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    pgdram_page_guard #(
        .T_RAS_MIN  (T_RAS_MIN),
        .T_RASP_MAX (T_RASP_MAX),
        .T_COLUMN   (T_CAS + T_CP)
    ) u_guard (
        .clk     (clk),
        .rst     (rst),
        .ras_low (ras_low),
        .min_ok  (min_ok),
        .expired (expired)
    );

    assign ras_low    = st_q inside {ST_RCD, ST_COLSET, ST_CASLO, ST_CASPRE, ST_OPEN};
    assign row_hit    = (req_addr[2*AW-1:AW] == cur_q.row);
    assign close_want = ref_req || expired || (req_valid && !row_hit);
    assign req_ready  = ((st_q == ST_IDLE) && !ref_req) ||
                        ((st_q == ST_OPEN) && !ref_req && !expired && row_hit);
    assign accept     = req_valid && req_ready;
    assign rd_grab    = (st_q == ST_CASLO) && tmr_done && !cur_q.write;

    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (st_q)
            ST_IDLE: begin
                if (ref_req)        st_d = ST_REFGNT;
                else if (req_valid) st_d = ST_ROWSET;
            end
            ST_ROWSET: begin
                st_d     = ST_RCD;
                tmr_load = 1'b1;
                tmr_val  = TW'(T_RCD - 1);
            end
            ST_RCD: begin
                if (tmr_done) st_d = ST_COLSET;
            end
            ST_COLSET: begin
                st_d     = ST_CASLO;
                tmr_load = 1'b1;
                tmr_val  = TW'(T_CAS - 1);
            end
            ST_CASLO: begin
                if (tmr_done) begin
                    st_d     = ST_CASPRE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(T_CP - 1);
                end
            end
            ST_CASPRE: begin
                if (tmr_done) st_d = ST_OPEN;
            end
            ST_OPEN: begin
                if (close_want) begin
                    if (min_ok) begin
                        st_d     = ST_PRECH;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(T_RP - 1);
                    end
                end else if (accept) begin
                    st_d = ST_COLSET;
                end
            end
            ST_PRECH: begin
                if (tmr_done) st_d = ST_IDLE;
            end
            ST_REFGNT: begin
                if (!ref_req) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            cur_q    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            st_q     <= st_d;
            rd_valid <= rd_grab;
            if (accept) begin
                cur_q.write <= req_write;
                cur_q.row   <= req_addr[2*AW-1:AW];
                cur_q.col   <= req_addr[AW-1:0];
                cur_q.be    <= req_be;
                cur_q.wdata <= req_wdata;
            end
            if (rd_grab) begin
                rd_data <= dram_dq_in & lane_mask(cur_q.be);
            end
        end
    end

    assign wr_phase    = cur_q.write && (st_q inside {ST_COLSET, ST_CASLO, ST_CASPRE});
    assign dram_ras_n  = !ras_low;
    assign dram_we_n   = !wr_phase;
    assign dram_dq_oe  = wr_phase;
    assign dram_dq_out = cur_q.wdata;
    assign dram_oe_n   = !((st_q == ST_CASLO) && !cur_q.write);
    assign dram_addr   = (st_q inside {ST_ROWSET, ST_RCD}) ? cur_q.row : cur_q.col;
    assign ref_gnt     = (st_q == ST_REFGNT);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign dram_cas_n[l] = !((st_q == ST_CASLO) && cur_q.be[l]);
    end

    // R1: outputs idle after a reset edge
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (dram_ras_n && (&dram_cas_n) && dram_we_n && dram_oe_n &&
                 !dram_dq_oe && !rd_valid && !ref_gnt));

    // R4: a column strobe is only low inside an open row
    a_r4_cas_inside_ras: assert property (@(posedge clk) disable iff (rst)
        !(&dram_cas_n) |-> !dram_ras_n);

    // R2: column address steady while a strobe stays low
    a_r2_col_stable: assert property (@(posedge clk) disable iff (rst)
        (!(&dram_cas_n) && $past(!(&dram_cas_n))) |-> $stable(dram_addr));

    // R6: never drive the bus while the memory may drive it
    a_r6_no_contention: assert property (@(posedge clk) disable iff (rst)
        dram_dq_oe |-> dram_oe_n);

    // R7: read strobe is a single-cycle pulse
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R8: a page hit keeps the row strobe low
    a_r8_hit_keeps_row: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_OPEN) && accept) |=> !dram_ras_n);

    // R11: bus fully released while refresh holds the grant
    a_r11_grant_quiet: assert property (@(posedge clk) disable iff (rst)
        ref_gnt |-> (dram_ras_n && (&dram_cas_n) && !req_ready));

endmodule

// File: tb/test_pgdram_ctrl.sv
`timescale 1ns/1ps
module test_pgdram_ctrl;

    localparam int AW      = 4;
    localparam int RASP    = 40;
    localparam int TRCD    = 3;
    localparam int TCAS    = 3;
    localparam int TCP     = 2;
    localparam int TRP     = 4;
    localparam int TRASMIN = 7;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_write;
    logic [7:0]  req_addr;
    logic [1:0]  req_be;
    logic [15:0] req_wdata;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        ref_req, ref_gnt;
    logic        ras_n, we_n, oe_n, dq_oe;
    logic [1:0]  cas_n;
    logic [3:0]  addr;
    logic [15:0] dq_out, dq_in;
    logic        cas_any;

    always #4 clk = ~clk;

    pgdram_ctrl #(.AW(AW), .T_RASP_MAX(RASP)) i_pgdram_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .ref_req(ref_req), .ref_gnt(ref_gnt),
        .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
        .dram_addr(addr), .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] f_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    // behavioural memory behind the strobes, and the bench's own expectation
    logic [15:0] mem_m [256];
    logic [15:0] mem_s [256];
    logic [15:0] exp_q [2048];
    int          wr_ptr = 0;
    int          rd_ptr = 0;

    logic [7:0]  last_addr;
    logic [1:0]  last_be;
    logic [15:0] last_wd;

    logic [3:0]  row_l;
    logic        prev_ras, prev_cas, cas_in_row;
    int          low_run, high_run, since_ras, cas_run, pre_run;
    int          ras_falls = 0;

    assign cas_any = ~&cas_n;

    always_comb begin
        for (int l = 0; l < 2; l++) begin
            dq_in[l*8 +: 8] = (!cas_n[l] && !oe_n) ? mem_m[{row_l, addr}][l*8 +: 8] : 8'hA5;
        end
    end

    always @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem_m[i] = 16'h0000;
            row_l = 4'h0; prev_ras = 1'b1; prev_cas = 1'b0; cas_in_row = 1'b0;
            low_run = 0; high_run = 100; since_ras = 0; cas_run = 0; pre_run = 100;
        end else begin
            if (prev_ras && !ras_n) begin
                ras_falls++;
                chk(high_run >= TRP, "R9 precharge", high_run, TRP);
                chk(addr == last_addr[7:4], "R2 row", addr, last_addr[7:4]);
                row_l = addr;
                low_run = 0; since_ras = 0; cas_in_row = 1'b0;
            end
            if (!prev_ras && ras_n) begin
                chk(low_run >= TRASMIN && low_run <= RASP, "R10 ras width", low_run, RASP);
                high_run = 0;
            end
            if (!ras_n) begin low_run++; since_ras++; end
            else high_run++;

            if (cas_any && !prev_cas) begin
                chk(~cas_n == last_be, "R5 lanes", ~cas_n, last_be);
                chk(addr == last_addr[3:0], "R2 column", addr, last_addr[3:0]);
                chk(since_ras > TRCD, "R3 ras-to-cas", since_ras, TRCD + 1);
                if (cas_in_row) chk(pre_run >= TCP, "R4 cas precharge", pre_run, TCP);
                if (!we_n) begin
                    chk(dq_oe && oe_n && dq_out == last_wd, "R6 write drive", dq_out, last_wd);
                    for (int l = 0; l < 2; l++)
                        if (!cas_n[l]) mem_m[{row_l, addr}][l*8 +: 8] = dq_out[l*8 +: 8];
                end else begin
                    chk(!dq_oe && !oe_n, "R7 read enables", {dq_oe, oe_n}, 0);
                end
                cas_in_row = 1'b1;
                cas_run = 0;
            end
            if (cas_any) cas_run++;
            else pre_run++;
            if (!cas_any && prev_cas) begin
                chk(cas_run == TCAS, "R4 cas width", cas_run, TCAS);
                pre_run = 1;
            end

            if (rd_valid) begin
                chk(prev_cas && !cas_any, "R7 data timing", {prev_cas, cas_any}, 2);
                chk(rd_ptr < wr_ptr, "R7 unexpected read", rd_ptr, wr_ptr);
                chk(rd_data == exp_q[rd_ptr], "R7 read data", rd_data, exp_q[rd_ptr]);
                rd_ptr++;
            end
            prev_ras = ras_n;
            prev_cas = cas_any;
        end
    end

    task automatic do_req(input bit wr, input logic [7:0] a, input logic [1:0] be, input logic [15:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        last_addr = a; last_be = be; last_wd = wd;
        if (wr) mem_s[a] = (mem_s[a] & ~f_mask(be)) | (wd & f_mask(be));
        else begin
            exp_q[wr_ptr] = mem_s[a] & f_mask(be);
            wr_ptr++;
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        chk(!req_ready, "R12 ready after accept", req_ready, 0);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R12 watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int f;
        logic [31:0] r;
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_be = 2'b11; req_wdata = '0; ref_req = 1'b0;
        last_addr = '0; last_be = '0; last_wd = '0;
        for (int i = 0; i < 256; i++) mem_s[i] = 16'h0000;
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(ras_n && cas_n == 2'b11, "R1 strobes", {ras_n, cas_n}, 7);
        chk(we_n && oe_n && !dq_oe, "R1 write/oe", {we_n, oe_n, dq_oe}, 6);
        chk(!rd_valid && !ref_gnt, "R1 status", {rd_valid, ref_gnt}, 0);
        rst = 1'b0;
        #1;
        chk(req_ready, "R12 ready when idle", req_ready, 1);

        // word write and read back
        do_req(1, 8'h12, 2'b11, 16'h1234);
        do_req(0, 8'h12, 2'b11, 16'h0);
        settle(50);
        chk(ras_n, "R10 idle row closed", ras_n, 1);

        // R8 page hits in one row
        f = ras_falls;
        do_req(1, 8'h30, 2'b11, 16'hBEEF);
        do_req(1, 8'h31, 2'b11, 16'hCAFE);
        do_req(0, 8'h30, 2'b11, 16'h0);
        settle(2);
        chk(ras_falls - f == 1, "R8 single activation", ras_falls - f, 1);
        settle(50);

        // R9 row miss
        f = ras_falls;
        do_req(1, 8'h40, 2'b11, 16'h4040);
        do_req(1, 8'h50, 2'b11, 16'h5050);
        settle(50);
        chk(ras_falls - f == 2, "R9 miss reopens", ras_falls - f, 2);

        // R5 byte lanes and R7 masked byte read
        do_req(1, 8'h61, 2'b11, 16'h0000);
        do_req(1, 8'h61, 2'b01, 16'hAB12);
        do_req(1, 8'h61, 2'b10, 16'hCD34);
        do_req(0, 8'h61, 2'b11, 16'h0);
        do_req(0, 8'h61, 2'b01, 16'h0);
        do_req(0, 8'h61, 2'b10, 16'h0);
        settle(50);
        chk(mem_s[8'h61] == 16'hCD12, "R5 lane merge", mem_s[8'h61], 16'hCD12);

        // R10 forced close on a run of hits
        f = ras_falls;
        for (int i = 0; i < 10; i++) do_req(i[0], {4'h7, i[3:0]}, 2'b11, 16'h7000 + i[15:0]);
        settle(50);
        chk(ras_falls - f >= 2, "R10 page limit close", ras_falls - f, 2);

        // R11 refresh hand-over from an open row
        do_req(1, 8'h90, 2'b11, 16'h5A5A);
        @(negedge clk);
        ref_req = 1'b1;
        for (int i = 0; i < 60 && !ref_gnt; i++) @(negedge clk);
        chk(ref_gnt, "R11 grant", ref_gnt, 1);
        chk(ras_n && cas_n == 2'b11, "R11 bus idle", {ras_n, cas_n}, 7);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h91; req_be = 2'b11;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(!req_ready && ras_n, "R11 no accept", {req_ready, ras_n}, 1);
        end
        req_valid = 1'b0;
        ref_req = 1'b0;
        f = ras_falls;
        do_req(0, 8'h90, 2'b11, 16'h0);
        settle(20);
        chk(ras_falls - f == 1, "R11 reopen after refresh", ras_falls - f, 1);

        // constrained random traffic
        r = $urandom(32'd20240611);
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a;
            logic [1:0] be;
            r = $urandom;
            a  = r[31] ? {4'h2, r[3:0]} : r[7:0];
            be = (r[9:8] == 2'b00) ? 2'b11 : r[9:8];
            do_req(r[10], a, be, r[27:12]);
        end
        settle(80);
        chk(rd_ptr == wr_ptr, "R7 all reads returned", rd_ptr, wr_ptr);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule